// File: doc/BRIEF.md
# RAM Pointer Register Unit

This block owns the 6-bit data-memory pointer of a small 4-bit controller. The pointer has two parts: a 2-bit register field in the upper bits, which picks a row, and a 4-bit digit field in the lower bits, which picks a nibble in that row. An external decoder hands the block one operation per cycle. Each operation comes with a code and its operands: a 2-bit toggle or row value `op_r`, a 4-bit immediate `op_d`, the current accumulator `acc_in` and the nibble `mem_rdata` that the RAM returns at the current pointer. The block drives back the new accumulator value and a RAM write. It also raises a skip request when the digit field wraps during an exchange-and-step operation.

The operation strobe `op_valid` is a plain control pin. The block takes an operation in every cycle where the strobe is high, so it has no ready signal and applies no back-pressure. The accumulator and RAM write strobes and data are combinational in the cycle of the operation. The RAM write address is the pointer value from before the update. The new pointer, the skip request and the load-immediate marker appear one clock edge later.

Top module: `ptr_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `ptr_b` reads 0 and `skip_req` and `lbi_flag` read 0 until an operation is taken.
- R2: Load-immediate (code 1) sets `ptr_b` to {op_r, op_d} at the next edge and sets `lbi_flag`. The flag stays high through further load-immediates and idle cycles, and clears after any other taken operation.
- R3: Exchange-and-increment (code 4) drives `acc_wdata`=`mem_rdata` and `mem_wdata`=`acc_in`, with both strobes high and `mem_addr` equal to the old pointer. It then sets the digit field to digit+1 mod 16 and XORs the register field with `op_r`.
- R4: Exchange-and-decrement (code 5) does the same data swap as R3, then sets the digit field to digit-1 mod 16 and XORs the register field with `op_r`.
- R5: `skip_req` is high for exactly the cycle after a code 4 taken with digit 15, or a code 5 taken with digit 0, and is low in every other cycle.
- R6: Exchange (code 3) swaps as in R3 but leaves the digit field unchanged; load (code 2) drives `acc_wdata`=`mem_rdata` without a RAM write. Both XOR the register field with `op_r`.
- R7: Store-immediate (code 6) writes `op_d` to the RAM at the old pointer and increments the digit field mod 16. It raises no skip, even on wrap, and leaves the register field unchanged.
- R8: Copy-A-to-B (code 7) sets the digit field to `acc_in` and keeps the register field. Copy-B-to-A (code 8) drives `acc_wdata` equal to the digit field and leaves the pointer unchanged.
- R9: Exchange-A-with-row (code 9) drives `acc_wdata`={2'b00, register field}, sets the register field to `acc_in[1:0]` and keeps the digit field.
- R10: A cycle with `op_valid` low, or an operation with code 0 or codes 10 to 15, writes nothing and leaves `ptr_b` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| op_r | input | 2 | Register-field toggle mask or load value |
| op_d | input | 4 | 4-bit immediate |
| acc_in | input | 4 | Current accumulator |
| mem_rdata | input | 4 | RAM nibble at `mem_addr` |
| ptr_b | output | 6 | Current pointer {register, digit} |
| mem_addr | output | 6 | RAM address, the pointer before update |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_wdata | output | 4 | RAM write data |
| acc_wr_en | output | 1 | Accumulator write strobe |
| acc_wdata | output | 4 | Accumulator write data |
| skip_req | output | 1 | Request to skip the next instruction |
| lbi_flag | output | 1 | A load-immediate was the last taken operation |

## Verification
Directed sequences walk the digit field across both wrap points. Exchange-and-increment at 15 and exchange-and-decrement at 0 must raise the skip, while store-immediate at 15 must wrap silently; this separates the skip logic from the plain counter. Back-to-back load-immediates and a single following operation show whether the marker is held or cleared. Long random streams mix every code, invalid codes included, with random strobe gaps and random row masks. These streams reveal a wrong field chosen for the XOR or a pointer that moves when nothing was taken.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [3:0] {
    OP_IDLE = 4'd0,
    OP_LBI  = 4'd1,
    OP_LD   = 4'd2,
    OP_X    = 4'd3,
    OP_XIS  = 4'd4,
    OP_XDS  = 4'd5,
    OP_STII = 4'd6,
    OP_CAB  = 4'd7,
    OP_CBA  = 4'd8,
    OP_XABR = 4'd9
  } ptr_op_e;

  typedef enum logic [1:0] {D_HOLD, D_INC, D_DEC, D_LOAD} dig_sel_e;
  typedef enum logic [1:0] {R_HOLD, R_XOR, R_LOAD} row_sel_e;
  typedef enum logic [1:0] {A_MEM, A_DIG, A_ROW} acc_src_e;
endpackage

// File: rtl/ptr_decode.sv
module ptr_decode
  import ptr_pkg::*;
(
  input  logic       op_valid,
  input  logic [3:0] op_code,
  output dig_sel_e   dig_sel,
  output logic       dig_from_acc,
  output row_sel_e   row_sel,
  output logic       row_from_acc,
  output logic       acc_we,
  output acc_src_e   acc_src,
  output logic       mem_we,
  output logic       mem_from_imm,
  output logic       skip_en,
  output logic       lbi_hit
);
  always_comb begin
    dig_sel      = D_HOLD;
    dig_from_acc = 1'b0;
    row_sel      = R_HOLD;
    row_from_acc = 1'b0;
    acc_we       = 1'b0;
    acc_src      = A_MEM;
    mem_we       = 1'b0;
    mem_from_imm = 1'b0;
    skip_en      = 1'b0;
    lbi_hit      = 1'b0;
    if (op_valid) begin
      case (op_code)
        OP_LBI: begin
          dig_sel = D_LOAD;
          row_sel = R_LOAD;
          lbi_hit = 1'b1;
        end
        OP_LD: begin
          acc_we  = 1'b1;
          row_sel = R_XOR;
        end
        OP_X: begin
          acc_we  = 1'b1;
          mem_we  = 1'b1;
          row_sel = R_XOR;
        end
        OP_XIS: begin
          acc_we  = 1'b1;
          mem_we  = 1'b1;
          row_sel = R_XOR;
          dig_sel = D_INC;
          skip_en = 1'b1;
        end
        OP_XDS: begin
          acc_we  = 1'b1;
          mem_we  = 1'b1;
          row_sel = R_XOR;
          dig_sel = D_DEC;
          skip_en = 1'b1;
        end
        OP_STII: begin
          mem_we       = 1'b1;
          mem_from_imm = 1'b1;
          dig_sel      = D_INC;
        end
        OP_CAB: begin
          dig_sel      = D_LOAD;
          dig_from_acc = 1'b1;
        end
        OP_CBA: begin
          acc_we  = 1'b1;
          acc_src = A_DIG;
        end
        OP_XABR: begin
          acc_we       = 1'b1;
          acc_src      = A_ROW;
          row_sel      = R_LOAD;
          row_from_acc = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ptr_digit_step.sv
module ptr_digit_step
  import ptr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  dig_sel_e     sel,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    nxt  = cur;
    wrap = 1'b0;
    case (sel)
      D_INC: begin
        nxt  = cur + ONE;
        wrap = (cur == TOP);
      end
      D_DEC: begin
        nxt  = cur - ONE;
        wrap = (cur == '0);
      end
      D_LOAD: nxt = load_val;
      default: ;
    endcase
  end
endmodule

// File: rtl/ptr_row_step.sv
module ptr_row_step
  import ptr_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] cur,
  input  row_sel_e     sel,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] nxt
);
  always_comb begin
    case (sel)
      R_XOR:   nxt = cur ^ mask;
      R_LOAD:  nxt = load_val;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ptr_unit.sv
module ptr_unit
  import ptr_pkg::*;
#(
  parameter int ROW_W = 2,
  parameter int DIG_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   op_valid,
  input  logic [3:0]             op_code,
  input  logic [ROW_W-1:0]       op_r,
  input  logic [DIG_W-1:0]       op_d,
  input  logic [DIG_W-1:0]       acc_in,
  input  logic [DIG_W-1:0]       mem_rdata,
  output logic [ROW_W+DIG_W-1:0] ptr_b,
  output logic [ROW_W+DIG_W-1:0] mem_addr,
  output logic                   mem_wr_en,
  output logic [DIG_W-1:0]       mem_wdata,
  output logic                   acc_wr_en,
  output logic [DIG_W-1:0]       acc_wdata,
  output logic                   skip_req,
  output logic                   lbi_flag
);
  localparam int PTR_W = ROW_W + DIG_W;

  logic [ROW_W-1:0] row_q, row_d, row_load;
  logic [DIG_W-1:0] dig_q, dig_d, dig_load;
  logic             dig_wrap;

  dig_sel_e dig_sel;
  row_sel_e row_sel;
  acc_src_e acc_src;
  logic     dig_from_acc, row_from_acc, mem_from_imm, skip_en, lbi_hit;

  ptr_decode u_dec (
    .op_valid    (op_valid),
    .op_code     (op_code),
    .dig_sel     (dig_sel),
    .dig_from_acc(dig_from_acc),
    .row_sel     (row_sel),
    .row_from_acc(row_from_acc),
    .acc_we      (acc_wr_en),
    .acc_src     (acc_src),
    .mem_we      (mem_wr_en),
    .mem_from_imm(mem_from_imm),
    .skip_en     (skip_en),
    .lbi_hit     (lbi_hit)
  );

  assign dig_load = dig_from_acc ? acc_in : op_d;
  assign row_load = row_from_acc ? acc_in[ROW_W-1:0] : op_r;

  ptr_digit_step #(.W(DIG_W)) u_dig (
    .cur     (dig_q),
    .sel     (dig_sel),
    .load_val(dig_load),
    .nxt     (dig_d),
    .wrap    (dig_wrap)
  );

  ptr_row_step #(.W(ROW_W)) u_row (
    .cur     (row_q),
    .sel     (row_sel),
    .mask    (op_r),
    .load_val(row_load),
    .nxt     (row_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q    <= '0;
      dig_q    <= '0;
      skip_req <= 1'b0;
      lbi_flag <= 1'b0;
    end else begin
      row_q    <= row_d;
      dig_q    <= dig_d;
      skip_req <= skip_en & dig_wrap;
      if (op_valid) lbi_flag <= lbi_hit;
    end
  end

  assign ptr_b     = {row_q, dig_q};
  assign mem_addr  = {row_q, dig_q};
  assign mem_wdata = mem_from_imm ? op_d : acc_in;

  always_comb begin
    case (acc_src)
      A_DIG:   acc_wdata = dig_q;
      A_ROW:   acc_wdata = {{(DIG_W-ROW_W){1'b0}}, row_q};
      default: acc_wdata = mem_rdata;
    endcase
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (ptr_b == '0 && !skip_req && !lbi_flag));

  // R2
  lbi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_LBI) |=> (lbi_flag && ptr_b == $past({op_r, op_d})));

  // R5
  skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |-> ($past(op_valid) &&
                  ($past(op_code) == OP_XIS || $past(op_code) == OP_XDS)));

  // R5
  inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_XIS && ptr_b[DIG_W-1:0] == {DIG_W{1'b1}})
      |=> (skip_req && ptr_b[DIG_W-1:0] == '0));

  // R7
  stii_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_STII) |=> (!skip_req && $stable(ptr_b[PTR_W-1:DIG_W])));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(ptr_b) && !skip_req));
endmodule

// File: tb/ptr_unit_tb.sv
`timescale 1ns/1ps
module ptr_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [1:0] op_r = '0;
  logic [3:0] op_d = '0;
  logic [3:0] acc_in = '0;
  logic [3:0] mem_rdata = '0;
  logic [5:0] ptr_b, mem_addr;
  logic       mem_wr_en, acc_wr_en, skip_req, lbi_flag;
  logic [3:0] mem_wdata, acc_wdata;

  int checks = 0;
  int fails  = 0;
  logic [5:0] m_b = '0;
  logic       m_lbi = 1'b0;
  logic       m_skip = 1'b0;

  always #2.5 clk = ~clk;

  ptr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_r(op_r), .op_d(op_d), .acc_in(acc_in), .mem_rdata(mem_rdata),
    .ptr_b(ptr_b), .mem_addr(mem_addr), .mem_wr_en(mem_wr_en),
    .mem_wdata(mem_wdata), .acc_wr_en(acc_wr_en), .acc_wdata(acc_wdata),
    .skip_req(skip_req), .lbi_flag(lbi_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] f_next_b(logic [5:0] b, logic v, logic [3:0] c,
                                          logic [1:0] r, logic [3:0] d, logic [3:0] a);
    logic [1:0] br = b[5:4];
    logic [3:0] bd = b[3:0];
    if (!v) return b;
    case (c)
      4'd1: return {r, d};
      4'd2, 4'd3: return {br ^ r, bd};
      4'd4: return {br ^ r, bd + 4'd1};
      4'd5: return {br ^ r, bd - 4'd1};
      4'd6: return {br, bd + 4'd1};
      4'd7: return {br, a};
      4'd9: return {a[1:0], bd};
      default: return b;
    endcase
  endfunction

  function automatic logic f_skip(logic [5:0] b, logic v, logic [3:0] c);
    return v && ((c == 4'd4 && b[3:0] == 4'hF) || (c == 4'd5 && b[3:0] == 4'h0));
  endfunction

  // drive at negedge, check combinational outputs, then registered ones after the edge
  task automatic do_op(input logic v, input logic [3:0] c, input logic [1:0] r,
                       input logic [3:0] d, input logic [3:0] a, input logic [3:0] m);
    logic e_awe, e_mwe;
    logic [3:0] e_ad, e_md;
    op_valid = v; op_code = c; op_r = r; op_d = d; acc_in = a; mem_rdata = m;
    e_awe = v && (c == 2 || c == 3 || c == 4 || c == 5 || c == 8 || c == 9);
    e_mwe = v && (c == 3 || c == 4 || c == 5 || c == 6);
    e_ad  = (c == 8) ? m_b[3:0] : (c == 9) ? {2'b00, m_b[5:4]} : m;
    e_md  = (c == 6) ? d : a;
    #1;
    chk(acc_wr_en == e_awe, "R6/R10 acc_wr_en", acc_wr_en, e_awe);
    chk(mem_wr_en == e_mwe, "R7/R10 mem_wr_en", mem_wr_en, e_mwe);
    chk(mem_addr == m_b, "R3 mem_addr old pointer", mem_addr, m_b);
    if (e_awe) chk(acc_wdata == e_ad, "R8/R9 acc_wdata", acc_wdata, e_ad);
    if (e_mwe) chk(mem_wdata == e_md, "R3/R7 mem_wdata", mem_wdata, e_md);
    m_skip = f_skip(m_b, v, c);
    m_b    = f_next_b(m_b, v, c, r, d, a);
    if (v) m_lbi = (c == 4'd1);
    @(posedge clk); #1;
    chk(ptr_b == m_b, "R2/R4 ptr_b", ptr_b, m_b);
    chk(skip_req == m_skip, "R5 skip_req", skip_req, m_skip);
    chk(lbi_flag == m_lbi, "R2 lbi_flag", lbi_flag, m_lbi);
    @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ptr_b == 6'd0 && !skip_req && !lbi_flag, "R1 reset", ptr_b, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ptr_b == 6'd0 && !skip_req && !lbi_flag, "R1 after release", ptr_b, 0);
    // R2 load-immediate, flag held across repeats and idle, cleared by other op
    do_op(1, 1, 2'd2, 4'hF, 0, 0);
    do_op(1, 1, 2'd1, 4'h3, 0, 0);
    do_op(0, 1, 2'd0, 4'h0, 0, 0);
    chk(lbi_flag == 1'b1, "R2 flag held idle", lbi_flag, 1);
    do_op(1, 1, 2'd2, 4'hF, 0, 0);
    // R3 / R5 exchange-increment at 15 wraps and skips
    do_op(1, 4, 2'd3, 0, 4'hA, 4'h5);
    chk(ptr_b == 6'b01_0000, "R3 increment wrap", ptr_b, 6'b010000);
    // R4 / R5 exchange-decrement at 0 wraps and skips
    do_op(1, 5, 2'd1, 0, 4'h6, 4'h9);
    chk(ptr_b == 6'b00_1111, "R4 decrement wrap", ptr_b, 6'b001111);
    // R7 store-immediate at 15: wrap with no skip, row kept
    do_op(1, 6, 2'd3, 4'hC, 0, 0);
    chk(skip_req == 1'b0, "R7 no skip on wrap", skip_req, 0);
    // R6 exchange and load
    do_op(1, 3, 2'd2, 0, 4'h1, 4'hE);
    do_op(1, 2, 2'd1, 0, 4'h2, 4'h7);
    // R8 copies
    do_op(1, 7, 0, 0, 4'hB, 0);
    do_op(1, 8, 0, 0, 4'h4, 0);
    // R9 exchange with row
    do_op(1, 9, 0, 0, 4'hE, 0);
    // R10 invalid codes and strobe low
    do_op(1, 4'd12, 2'd3, 4'h5, 4'h5, 4'h5);
    do_op(0, 4, 2'd3, 0, 4'h5, 4'h5);
    do_op(1, 0, 2'd3, 4'h5, 4'h5, 4'h5);
    // random mix of all codes
    for (int i = 0; i < 400; i++) begin
      do_op(($urandom % 5) != 0, 4'($urandom % 16), 2'($urandom), 4'($urandom),
            4'($urandom), 4'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule